// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block keeps the status flags of an I2C slave port. It watches the bus data and clock lines and passes both through a synchronizer clocked by the system clock, so the bus is oversampled. It detects START and STOP conditions and records which of the two occurred most recently. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high.

The surrounding slave logic reports byte-level events through single-cycle pulses: an address match with its direction bit, a data byte received, a transmit buffer loaded, a transmit byte finished, a buffer read and an acknowledge clock. The block turns these pulses into four flags. The first says whether the last byte was address or data. The second holds the captured read/write bit, with a qualifier that marks the window in which that bit is meaningful. The third is a buffer-full indication. Address comparison, acknowledge driving and clock stretching stay in the surrounding logic.

When the enable input is low, every flag is forced to zero and bus conditions and byte pulses are ignored. The synchronizer keeps tracking the bus while the block is disabled, so enabling the block does not produce a false edge.

Top module: `i2cs_status_trk`

## Requirements
- R1: A data-line fall (1 to 0) while the clock line stays high sets `start_seen` to 1 and clears `stop_seen` to 0. The change appears on the third rising clock edge after the line change.
- R2: A data-line rise (0 to 1) while the clock line stays high sets `stop_seen` to 1 and clears `start_seen` to 0, with the same latency as R1.
- R3: `start_seen` and `stop_seen` are never 1 together. Data-line changes while the clock line is low change neither flag.
- R4: While `en` is 0, all outputs are 0 on the next clock. Bus conditions and byte pulses that arrive while `en` is 0 are ignored and leave no trace after re-enable.
- R5: An `addr_match` pulse sets the following on the next clock: `data_not_addr` to 0 (0 = address), `rw_bit` to `addr_rw` (1 = read, 0 = write), `rw_valid` to 1 and `buf_full` to 1.
- R6: `rw_valid` drops to 0 on the clock after the first START, STOP or `ack_p` that follows the match, while `rw_bit` keeps its value. When `addr_match` arrives in the same cycle as one of these events, the match wins.
- R7: An `rx_byte_done` pulse sets `data_not_addr` to 1 and `buf_full` to 1. If `addr_match` arrives in the same cycle, `data_not_addr` follows the match.
- R8: A `buf_read` pulse clears `buf_full`. When a set event (`addr_match`, `rx_byte_done` or `tx_load`) arrives in the same cycle, `buf_full` is set instead.
- R9: A `tx_load` pulse sets `buf_full`. A `tx_byte_done` pulse clears `buf_full` and sets `data_not_addr` to 1.
- R10: After a synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Module enable; when low, all flags are held at 0 |
| sda_in | input | 1 | Filtered bus data line |
| scl_in | input | 1 | Filtered bus clock line |
| addr_match | input | 1 | Pulse: the address byte matched this slave |
| addr_rw | input | 1 | Direction bit sent with the address (1 = read) |
| rx_byte_done | input | 1 | Pulse: a data byte was received into the buffer |
| tx_load | input | 1 | Pulse: the transmit buffer was loaded |
| tx_byte_done | input | 1 | Pulse: a transmitted byte has finished |
| buf_read | input | 1 | Pulse: the buffer was read |
| ack_p | input | 1 | Pulse: acknowledge clock of the current byte |
| start_seen | output | 1 | START was the most recent bus condition |
| stop_seen | output | 1 | STOP was the most recent bus condition |
| data_not_addr | output | 1 | 1 = last byte was data, 0 = address |
| rw_bit | output | 1 | Captured direction bit (1 = read) |
| rw_valid | output | 1 | `rw_bit` is inside its validity window |
| buf_full | output | 1 | Buffer holds an unconsumed byte or a pending transmit |

## Verification
The assertions check on every cycle that the START and STOP flags never coexist, that disabling clears every flag, and how each byte pulse acts on the flags one cycle later. This covers the set-over-clear priority of the buffer flag and the end of the read/write window on an acknowledge. Only the bench scenarios can show the end-to-end path from the bus lines through the synchronizer: START and STOP detection with their exact latency, the absence of events when the data line changes while the clock is low, and the window closing on a START or a STOP. Two more behaviours are also left to the bench: the enable switch leaves no trace, and a cumulative sequence of pulse patterns gives the expected flags.

// File: rtl/i2cs_status_pkg.sv
// Package: shared types for the I2C slave status tracker.
// Assumes: all strobe fields are single-cycle pulses in the clk domain.
package i2cs_status_pkg;

    // Bus conditions found on the synchronized lines.
    typedef struct packed {
        logic start;
        logic stop;
    } bus_evt_t;

    // Byte-level pulses from the surrounding slave logic.
    typedef struct packed {
        logic addr_match;
        logic addr_rw;
        logic rx_done;
        logic tx_load;
        logic tx_done;
        logic buf_read;
        logic ack;
    } byte_evt_t;

    // Flags presented at the port.
    typedef struct packed {
        logic start_seen;
        logic stop_seen;
        logic data_not_addr;
        logic rw_bit;
        logic rw_valid;
        logic buf_full;
    } stat_flags_t;

endpackage

// File: rtl/i2cs_sync.sv
// Module: i2cs_sync
// Multi-bit, multi-stage flip-flop synchronizer. Each bit passes through
// STAGES registers in series.
// Assumes: each bit is independent (no bus coherency is needed) and the
// inputs idle at RST_VAL, which is loaded on reset.
module i2cs_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                // Purpose: further resolution stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond_det.sv
// Module: i2cs_cond_det
// Finds START (data falls, clock high) and STOP (data rises, clock high)
// on synchronized bus lines by comparing them with the previous sample.
// Assumes: the inputs are already synchronous to clk and idle high after
// reset. The clock must be high in both samples for an event to count.
module i2cs_cond_det
    import i2cs_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sda_s,
    input  logic     scl_s,
    output bus_evt_t evt
);
    logic sda_q;
    logic scl_q;

    // Purpose: hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_s;
            scl_q <= scl_s;
        end
    end

    // Purpose: classify the data-line edge while the clock stays high.
    always_comb begin
        evt.start = sda_q & ~sda_s & scl_q & scl_s;
        evt.stop  = ~sda_q & sda_s & scl_q & scl_s;
    end
endmodule

// File: rtl/i2cs_flag_regs.sv
// Module: i2cs_flag_regs
// Status flag registers. They are updated from bus conditions and
// byte-level pulses. Set events take priority over clear events on the
// buffer flag, and an address match takes priority over everything else.
// Assumes: all event inputs are single-cycle pulses; en low forces all
// flags to zero.
module i2cs_flag_regs
    import i2cs_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  bus_evt_t    bus,
    input  byte_evt_t   be,
    output stat_flags_t flags
);
    stat_flags_t nxt;
    logic        bf_set;
    logic        bf_clr;

    // Purpose: next-state logic for every flag.
    always_comb begin
        nxt    = flags;
        bf_set = be.addr_match | be.rx_done | be.tx_load;
        bf_clr = be.buf_read | be.tx_done;

        if (bus.start) begin
            nxt.start_seen = 1'b1;
            nxt.stop_seen  = 1'b0;
        end else if (bus.stop) begin
            nxt.start_seen = 1'b0;
            nxt.stop_seen  = 1'b1;
        end

        if (be.addr_match)                nxt.data_not_addr = 1'b0;
        else if (be.rx_done | be.tx_done) nxt.data_not_addr = 1'b1;

        if (be.addr_match) begin
            nxt.rw_bit   = be.addr_rw;
            nxt.rw_valid = 1'b1;
        end else if (bus.start | bus.stop | be.ack) begin
            nxt.rw_valid = 1'b0;
        end

        if (bf_set)      nxt.buf_full = 1'b1;
        else if (bf_clr) nxt.buf_full = 1'b0;

        if (!en) nxt = '0;
    end

    // Purpose: flag state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end
endmodule

// File: rtl/i2cs_status_trk.sv
// Module: i2cs_status_trk (top)
// I2C slave bus status tracker: synchronizer, condition detector and flag
// registers. The synchronizer keeps running while disabled, so enabling the
// block never produces a false bus edge.
// Assumes: byte pulses are one clk wide; sda_in/scl_in are glitch-filtered.
module i2cs_status_trk
    import i2cs_status_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sda_in,
    input  logic scl_in,
    input  logic addr_match,
    input  logic addr_rw,
    input  logic rx_byte_done,
    input  logic tx_load,
    input  logic tx_byte_done,
    input  logic buf_read,
    input  logic ack_p,
    output logic start_seen,
    output logic stop_seen,
    output logic data_not_addr,
    output logic rw_bit,
    output logic rw_valid,
    output logic buf_full
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_raw;
    logic [LINES-1:0] line_s;
    bus_evt_t         bus_evt;
    byte_evt_t        byte_evt;
    stat_flags_t      flags;

    assign line_raw = {scl_in, sda_in};

    i2cs_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (LINES),
        .RST_VAL ({LINES{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_raw),
        .q     (line_s)
    );

    i2cs_cond_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .sda_s (line_s[0]),
        .scl_s (line_s[1]),
        .evt   (bus_evt)
    );

    // Purpose: gather the byte-level pulses into one bundle.
    always_comb begin
        byte_evt.addr_match = addr_match;
        byte_evt.addr_rw    = addr_rw;
        byte_evt.rx_done    = rx_byte_done;
        byte_evt.tx_load    = tx_load;
        byte_evt.tx_done    = tx_byte_done;
        byte_evt.buf_read   = buf_read;
        byte_evt.ack        = ack_p;
    end

    i2cs_flag_regs u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .bus   (bus_evt),
        .be    (byte_evt),
        .flags (flags)
    );

    assign start_seen    = flags.start_seen;
    assign stop_seen     = flags.stop_seen;
    assign data_not_addr = flags.data_not_addr;
    assign rw_bit        = flags.rw_bit;
    assign rw_valid      = flags.rw_valid;
    assign buf_full      = flags.buf_full;
endmodule

// File: rtl/i2cs_status_trk_chk.sv
// Module: i2cs_status_trk_chk
// Port-level property checker for i2cs_status_trk, attached by bind.
// Assumes: the same clock and reset as the tracker.
module i2cs_status_trk_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sda_in,
    input logic scl_in,
    input logic addr_match,
    input logic addr_rw,
    input logic rx_byte_done,
    input logic tx_load,
    input logic tx_byte_done,
    input logic buf_read,
    input logic ack_p,
    input logic start_seen,
    input logic stop_seen,
    input logic data_not_addr,
    input logic rw_bit,
    input logic rw_valid,
    input logic buf_full
);
    assert_start_stop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen));

    assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(start_seen || stop_seen || data_not_addr || rw_bit || rw_valid || buf_full));

    assert_match_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && addr_match) |=> (rw_valid && !data_not_addr && buf_full && (rw_bit == $past(addr_rw))));

    assert_ack_ends_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ack_p && !addr_match) |=> !rw_valid);

    assert_rx_sets_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_byte_done && !addr_match) |=> (buf_full && data_not_addr));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && buf_read && !addr_match && !rx_byte_done && !tx_load) |=> !buf_full);

    assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_byte_done && !addr_match && !rx_byte_done && !tx_load) |=> (!buf_full && data_not_addr));

    assert_tx_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_load) |=> buf_full);
endmodule

bind i2cs_status_trk i2cs_status_trk_chk u_chk (.*);

// File: tb/i2cs_status_trk_tb.sv
module i2cs_status_trk_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic sda_in = 1'b1, scl_in = 1'b1;
    logic addr_match = 0, addr_rw = 0, rx_byte_done = 0, tx_load = 0;
    logic tx_byte_done = 0, buf_read = 0, ack_p = 0;
    logic start_seen, stop_seen, data_not_addr, rw_bit, rw_valid, buf_full;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    i2cs_status_trk u_dut (.*);

    // Vector: [10]addr_match [9]rx_byte_done [8]tx_load [7]tx_byte_done
    // [6]buf_read [5]ack_p [4]addr_rw | expected [3]buf_full [2]data_not_addr
    // [1]rw_bit [0]rw_valid. Applied one cycle each; effects are cumulative.
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        11'b1000001_1011,   // R5 match, read
        11'b0000100_0011,   // R8 buffer read
        11'b0000010_0010,   // R6 ack ends window
        11'b0010000_1010,   // R9 tx load
        11'b0001000_0110,   // R9 tx done
        11'b1000000_1001,   // R5 match, write
        11'b0100100_1101,   // R8/R7 set wins over read
        11'b1000011_1011,   // R6 match wins over ack
        11'b0000100_0011,   // R8 read
        11'b0000000_0011,   // hold
        11'b0011000_1111,   // R9 load wins over done
        11'b0000010_1110    // R6 ack
    };

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {start_seen, stop_seen, data_not_addr, rw_bit, rw_valid, buf_full};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog actual=running expected=finished");
        errors++;
        checks++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R10 reset", outs(), 6'b0);
        rst_n = 1'b1;
        en = 1'b1;
        cyc(4);
        chk("R10 after reset idle bus", outs(), 6'b0);

        // Vector walk over byte pulses.
        for (int i = 0; i < NV; i++) begin
            {addr_match, rx_byte_done, tx_load, tx_byte_done, buf_read, ack_p, addr_rw} = VEC[i][10:4];
            cyc(1);
            {addr_match, rx_byte_done, tx_load, tx_byte_done, buf_read, ack_p, addr_rw} = '0;
            chk($sformatf("R5-9 vector %0d", i), outs() & 6'b001111, {2'b00, VEC[i][2], VEC[i][1], VEC[i][0], VEC[i][3]});
        end

        // R1: START with exact latency: flag changes on third rising edge.
        addr_match = 1; addr_rw = 1; cyc(1); addr_match = 0;
        sda_in = 1'b0;
        cyc(2);
        chk("R1 no flag before third edge", {start_seen, stop_seen}, 2'b00);
        cyc(1);
        chk("R1 start detected", {start_seen, stop_seen}, 2'b10);
        chk("R6 start ends window", {rw_valid, rw_bit}, 2'b01);

        // R3: data toggles while clock low give no event.
        scl_in = 1'b0; cyc(3);
        sda_in = 1'b1; cyc(3);
        sda_in = 1'b0; cyc(3);
        chk("R3 data change with clock low", {start_seen, stop_seen}, 2'b10);

        // R2: STOP.
        addr_match = 1; addr_rw = 0; cyc(1); addr_match = 0;
        scl_in = 1'b1; cyc(3);
        sda_in = 1'b1; cyc(4);
        chk("R2 stop detected", {start_seen, stop_seen}, 2'b01);
        chk("R6 stop ends window", rw_valid, 1'b0);

        // R4: disable clears and ignores.
        tx_load = 1; cyc(1); tx_load = 0;
        en = 1'b0; cyc(1);
        chk("R4 disable clears", outs(), 6'b0);
        sda_in = 1'b0; rx_byte_done = 1; addr_match = 1; cyc(1);
        rx_byte_done = 0; addr_match = 0; cyc(5);
        chk("R4 ignored while disabled", outs(), 6'b0);
        en = 1'b1; cyc(4);
        chk("R4 no trace after enable", outs(), 6'b0);

        // R1 again after re-enable: STOP then START.
        sda_in = 1'b1; cyc(4);
        chk("R2 stop after enable", {start_seen, stop_seen}, 2'b01);
        sda_in = 1'b0; cyc(4);
        chk("R1 start after stop", {start_seen, stop_seen}, 2'b10);

        // R10: reset mid-operation.
        rx_byte_done = 1; cyc(1); rx_byte_done = 0;
        rst_n = 1'b0; cyc(1);
        chk("R10 reset mid-run", outs(), 6'b0);
        rst_n = 1'b1;
        cyc(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule